// File: doc/BRIEF.md
# Host Access Steering Decoder

This block sits behind the host register port of a device that contains four processing channels. Up to sixteen such devices may share one host port. The block holds two host-visible registers. The control register carries an auto-step flag, a group-write flag, a 4-bit selector field and a 2-bit channel field. The address register holds the 8-bit internal address that the channels use.

Each cycle the block combines the control register with the device identity straps and two upper host address bits. From these it produces a registered enable vector with one bit per channel. With the group-write flag clear, the device answers only when the selector matches its straps. With the flag set, the selector is read as a group code. A group code can pick fixed sets of channels, or every device whose low identity bits match a pattern, so one host write can configure many devices at once.

Every access to the channel data register can advance the address by one. Register readback is blocked while group-write is active, because several devices would then drive the shared bus.

Top module: `hp_access_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the control and address registers clear to zero. In that state `chan_en` reads 0, `chan_addr` reads 0x00, `host_rdata` reads 0x00 and `rd_valid` reads 1.
- R2: Host register select `host_sel` = 0 addresses the control register and `host_sel` = 1 the address register. Control bit 7 is auto-step, bit 6 is group-write, bits 5:2 are the selector and bits 1:0 are the channel field. With bit 6 clear and the selector equal to `dev_id`, `chan_en` has exactly bit [channel field] set.
- R3: With bit 6 clear and the selector different from `dev_id`, `chan_en` is 0.
- R4: With bit 6 set, selector 0000 enables all four channels, 0001 enables channels 0..2 (0x7) and 0010 enables channels 1..3 (0xE), whatever `dev_id` is.
- R5: With bit 6 set and selector 0100, every device enables only the channel numbered by `upper_addr`. The channel field is ignored.
- R6: With bit 6 set, selector 1000 or 1001 enables channel `upper_addr` only when `dev_id[0]` equals selector bit 0. Otherwise `chan_en` is 0.
- R7: With bit 6 set, selectors 1100 to 1111 enable channel `upper_addr` only when `dev_id[1:0]` equals selector bits 1:0. Otherwise `chan_en` is 0.
- R8: With bit 6 set, any other selector code gives `chan_en` = 0.
- R9: `chan_en` follows the control register, `dev_id` and `upper_addr` one clock edge after they are sampled.
- R10: When auto-step (bit 7) is set, each cycle with `data_acc` high adds one to the address, wrapping from 0xFF to 0x00. When auto-step is clear, `data_acc` leaves the address unchanged.
- R11: A host write to the address register wins over an increment in the same cycle.
- R12: `rd_valid` equals the inverse of control bit 6. One edge after a `host_rd`, `host_rdata` shows the selected register when `rd_valid` was high. At every other time it shows 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select: 0 control, 1 address |
| host_wdata | input | 8 | Host write data |
| data_acc | input | 1 | Channel data register access strobe |
| dev_id | input | 4 | Device identity straps |
| upper_addr | input | 2 | Upper host address bits naming a channel |
| chan_en | output | 4 | Per-channel access enable |
| chan_addr | output | 8 | Internal channel address |
| rd_valid | output | 1 | Readback permitted |
| host_rdata | output | 8 | Readback data |

## Verification
A register write lands on the edge that samples it. `chan_en` needs one further edge, so the bench checks enables two falling edges after the write strobe is driven. `chan_addr` and `rd_valid` are checked at the first falling edge after the write or `data_acc` cycle. `host_rdata` is checked at the falling edge that follows the read strobe's cycle. All inputs change on falling edges and all outputs are sampled there, so each check lands between the edges that define its result.

// File: rtl/hpad_pkg.sv
package hpad_pkg;
  localparam int ID_W = 4;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;

  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_ALL,
    GRP_LOWER,
    GRP_UPPER,
    GRP_ONE
  } grp_t;
endpackage

// File: rtl/hpad_regs.sv
module hpad_regs
  import hpad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              data_acc,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] addr_q
);
  localparam int AUTO_BIT = DATA_W - 1;

  logic ctrl_wr, addr_wr, step;
  assign ctrl_wr = host_wr && (host_sel == SEL_CTRL);
  assign addr_wr = host_wr && (host_sel == SEL_ADDR);
  assign step    = data_acc && ctrl_q[AUTO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      addr_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= host_wdata;
      if (addr_wr)   addr_q <= host_wdata;
      else if (step) addr_q <= addr_q + 1'b1;
    end
  end

  // R11: address write wins over a same-cycle step
  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> addr_q == $past(host_wdata));
  // R10: a step adds one, modulo the register width
  a_r10_step_wraps: assert property (@(posedge clk) disable iff (rst)
    (!addr_wr && data_acc && ctrl_q[AUTO_BIT]) |=> addr_q == DATA_W'($past(addr_q) + 1'b1));
  // R10: no step without auto-step
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!addr_wr && !ctrl_q[AUTO_BIT]) |=> $stable(addr_q));
endmodule

// File: rtl/hpad_decode.sv
module hpad_decode
  import hpad_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             group_wr,
  input  logic [ID_W-1:0]  selector,
  input  logic [SEL_W-1:0] chan_field,
  input  logic [ID_W-1:0]  dev_id,
  input  logic [SEL_W-1:0] upper_addr,
  output logic [NUM_CH-1:0] chan_en
);
  grp_t             grp;
  logic [SEL_W-1:0] pick;
  logic [NUM_CH-1:0] next_en;

  always_comb begin
    grp  = GRP_NONE;
    pick = chan_field;
    if (!group_wr) begin
      if (selector == dev_id) grp = GRP_ONE;
    end else begin
      pick = upper_addr;
      casez (selector)
        4'b0000: grp = GRP_ALL;
        4'b0001: grp = GRP_LOWER;
        4'b0010: grp = GRP_UPPER;
        4'b0100: grp = GRP_ONE;
        4'b100?: if (dev_id[0] == selector[0]) grp = GRP_ONE;
        4'b11??: if (dev_id[1:0] == selector[1:0]) grp = GRP_ONE;
        default: grp = GRP_NONE;
      endcase
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign next_en[ch] = (grp == GRP_ALL) ||
                         ((grp == GRP_LOWER) && (ch != NUM_CH - 1)) ||
                         ((grp == GRP_UPPER) && (ch != 0)) ||
                         ((grp == GRP_ONE) && (pick == SEL_W'(ch)));
  end

  always_ff @(posedge clk) begin
    if (rst) chan_en <= '0;
    else     chan_en <= next_en;
  end

  // R2: a directed access reaches at most one channel
  a_r2_single_channel: assert property (@(posedge clk) disable iff (rst)
    !group_wr |=> $onehot0(chan_en));
  // R4: the all-channels code enables every channel
  a_r4_all_channels: assert property (@(posedge clk) disable iff (rst)
    (group_wr && selector == 4'b0000) |=> (&chan_en));
  // R8: an unassigned group code enables nothing
  a_r8_unassigned: assert property (@(posedge clk) disable iff (rst)
    (group_wr && selector == 4'b0011) |=> (chan_en == '0));
endmodule

// File: rtl/hpad_readback.sv
module hpad_readback
  import hpad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] host_rdata
);
  always_ff @(posedge clk) begin
    if (rst || !host_rd || !rd_valid) host_rdata <= '0;
    else if (host_sel == SEL_CTRL)    host_rdata <= ctrl_q;
    else if (host_sel == SEL_ADDR)    host_rdata <= addr_q;
    else                              host_rdata <= '0;
  end

  // R12: a blocked readback returns zero
  a_r12_blocked_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> (host_rdata == '0));
endmodule

// File: rtl/hp_access_decoder.sv
module hp_access_decoder
  import hpad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              data_acc,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [SEL_W-1:0]  upper_addr,
  output logic [NUM_CH-1:0] chan_en,
  output logic [DATA_W-1:0] chan_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int GRP_BIT = DATA_W - 2;
  localparam int SELECTOR_LO = SEL_W;

  logic [DATA_W-1:0] ctrl_q;

  hpad_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .data_acc(data_acc),
    .ctrl_q(ctrl_q), .addr_q(chan_addr)
  );

  hpad_decode #(.NUM_CH(NUM_CH)) u_decode (
    .clk(clk), .rst(rst),
    .group_wr(ctrl_q[GRP_BIT]),
    .selector(ctrl_q[SELECTOR_LO +: ID_W]),
    .chan_field(ctrl_q[SEL_W-1:0]),
    .dev_id(dev_id), .upper_addr(upper_addr),
    .chan_en(chan_en)
  );

  assign rd_valid = !ctrl_q[GRP_BIT];

  hpad_readback #(.DATA_W(DATA_W)) u_readback (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_sel(host_sel),
    .rd_valid(rd_valid), .ctrl_q(ctrl_q), .addr_q(chan_addr),
    .host_rdata(host_rdata)
  );
endmodule

// File: tb/hp_access_decoder_bench.sv
`timescale 1ns/1ps
module hp_access_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, data_acc = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [3:0] dev_id = 4'd0;
  logic [1:0] upper_addr = 2'd0;
  logic [3:0] chan_en;
  logic [7:0] chan_addr, host_rdata;
  logic       rd_valid;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  hp_access_decoder u_hp_access_decoder (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .data_acc(data_acc),
    .dev_id(dev_id), .upper_addr(upper_addr), .chan_en(chan_en),
    .chan_addr(chan_addr), .rd_valid(rd_valid), .host_rdata(host_rdata)
  );

  function automatic logic [3:0] want_en(input logic [7:0] c, input logic [3:0] id,
                                         input logic [1:0] up);
    logic [3:0] s;
    s = c[5:2];
    if (!c[6]) return (s == id) ? (4'b1 << c[1:0]) : 4'b0;
    case (s)
      4'b0000: return 4'hF;
      4'b0001: return 4'h7;
      4'b0010: return 4'hE;
      4'b0100: return 4'b1 << up;
      4'b1000, 4'b1001: return (id[0] == s[0]) ? (4'b1 << up) : 4'b0;
      4'b1100, 4'b1101, 4'b1110, 4'b1111:
        return (id[1:0] == s[1:0]) ? (4'b1 << up) : 4'b0;
      default: return 4'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // write control, let chan_en settle one edge later, then compare
  task automatic try_ctrl(input string req, input logic [7:0] c,
                          input logic [3:0] id, input logic [1:0] up);
    dev_id = id; upper_addr = up;
    wr_reg(2'd0, c);
    @(negedge clk);
    check(req, {4'h0, chan_en}, {4'h0, want_en(c, id, up)});
  endtask

  task automatic read_reg(input logic [1:0] sel);
    @(negedge clk);
    host_rd = 1'b1; host_sel = sel;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 chan_en", {4'h0, chan_en}, 8'h00);
    check("R1 chan_addr", chan_addr, 8'h00);
    check("R1 host_rdata", host_rdata, 8'h00);
    check("R1 rd_valid", {7'd0, rd_valid}, 8'h01);
    rst = 1'b0;

    try_ctrl("R2 match", {2'b00, 4'd9, 2'd2}, 4'd9, 2'd0);
    try_ctrl("R2 match ch3", {2'b00, 4'd5, 2'd3}, 4'd5, 2'd1);
    try_ctrl("R3 mismatch", {2'b00, 4'd9, 2'd2}, 4'd8, 2'd0);
    try_ctrl("R4 all", 8'b0100_0000, 4'd7, 2'd1);
    try_ctrl("R4 low three", 8'b0100_0111, 4'd2, 2'd3);
    try_ctrl("R4 high three", 8'b0100_1000, 4'd2, 2'd0);
    try_ctrl("R5 upper picks, field ignored", 8'b0101_0011, 4'd3, 2'd1);
    try_ctrl("R6 id bit0 match", 8'b0110_0101, 4'd7, 2'd2);
    try_ctrl("R6 id bit0 miss", 8'b0110_0101, 4'd6, 2'd2);
    try_ctrl("R7 low bits match", 8'b0111_1000, 4'd14, 2'd3);
    try_ctrl("R7 low bits miss", 8'b0111_1000, 4'd13, 2'd3);
    try_ctrl("R8 unassigned", 8'b0100_1100, 4'd0, 2'd0);
    try_ctrl("R8 unassigned 0101", 8'b0101_0100, 4'd5, 2'd1);

    // R9: a strap change alone moves chan_en one edge later
    try_ctrl("R9 setup", 8'b0101_0000, 4'd0, 2'd0);
    @(negedge clk); upper_addr = 2'd3;
    check("R9 before edge", {4'h0, chan_en}, 8'h01);
    @(negedge clk);
    check("R9 after edge", {4'h0, chan_en}, 8'h08);

    // R12 readback gating
    wr_reg(2'd0, 8'h45);
    check("R12 valid cleared", {7'd0, rd_valid}, 8'h00);
    read_reg(2'd0);
    check("R12 blocked read", host_rdata, 8'h00);
    wr_reg(2'd0, 8'h85);
    wr_reg(2'd1, 8'h3C);
    read_reg(2'd1);
    check("R12 addr read", host_rdata, 8'h3C);
    read_reg(2'd0);
    check("R12 ctrl read", host_rdata, 8'h85);
    @(negedge clk);
    check("R12 idle zero", host_rdata, 8'h00);

    // R10 step and wrap
    wr_reg(2'd1, 8'hFE);
    @(negedge clk); data_acc = 1'b1;
    repeat (3) @(negedge clk);
    data_acc = 1'b0;
    check("R10 wrap", chan_addr, 8'h01);
    wr_reg(2'd0, 8'h05);
    @(negedge clk); data_acc = 1'b1;
    repeat (2) @(negedge clk);
    data_acc = 1'b0;
    check("R10 no step", chan_addr, 8'h01);
    // R11 write beats step
    wr_reg(2'd0, 8'h80);
    @(negedge clk);
    host_wr = 1'b1; host_sel = 2'd1; host_wdata = 8'h40; data_acc = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; data_acc = 1'b0;
    check("R11 write wins", chan_addr, 8'h40);

    // constrained random decode and readback
    for (int i = 0; i < 400; i++) begin
      logic [3:0] sel4;
      logic [3:0] lst [8];
      lst = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h9, 4'hC, 4'hF};
      c = 8'($urandom);
      if ($urandom_range(1, 0) == 1) begin
        sel4 = lst[$urandom_range(7, 0)];
        c[5:2] = sel4;
      end
      try_ctrl("R2-R8 random decode", c, 4'($urandom), 2'($urandom));
      read_reg(2'd0);
      check("R12 random readback", host_rdata, c[6] ? 8'h00 : c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule